// File: doc/BRIEF.md
# Compare-Branch Fusing Decode Stage

This stage sits between an instruction fetch buffer and the rename or dispatch logic. Each cycle it looks at a window of up to five instruction records that have already been classified. Every record carries a class code, two source operands, a condition code and a jump target. The stage turns the window into up to four internal operations, keeping program order.

When a compare or test record is directly followed by a conditional jump, the two are merged into one fused operation. That operation carries the compare operands and flag opcode together with the jump condition and target. Only the first such pair in a window is merged. Because the merged pair fills one slot, a cycle with a fusion can retire five records into four slots.

The stage reports how many records it took from the window, so the fetch buffer can shift by that amount in the same cycle. The operation slots are registered and handed downstream with a valid/ready handshake. A stalled output holds its contents, and no records are taken while it is stalled.

Top module: `mf_fuse_decode`

## Requirements
- R1: While `rst` is high, `out_valid` and every bit of `out_vld` are cleared on the clock edge.
- R2: Records are valid at indices 0 to `in_cnt`-1, with record i at bits [i*W +: W] of each window field. Each record that is not fused fills one output slot, in program order. At most four slots fill per cycle, and the valid slots always form a prefix from slot 0.
- R3: A fused slot is formed when a compare (class 1) or test (class 2) record is directly followed by a conditional jump (class 3). Its `out_fused` bit is set. Its class and both operands come from the compare or test record, and its condition and target come from the jump record.
- R4: At most one fused slot is produced per cycle. With one fusion, up to five records are taken.
- R5: When a window holds several eligible pairs, only the lowest-indexed pair is fused. Later pairs are emitted as separate plain slots while slots remain.
- R6: A compare or test that is the last valid record of the window is not taken and is not emitted. It stays in the fetch buffer for the next cycle.
- R7: A compare or test followed by a record that is not a conditional jump, or a conditional jump that does not follow a compare or test, is emitted as a plain slot (`out_fused` = 0). Class 0 marks any other instruction.
- R8: While `out_valid` is high and `out_ready` is low, `in_take` is 0 and all output slots hold their values.
- R9: An empty window (`in_cnt` = 0) loaded into the output register leaves `out_valid` low and takes nothing.
- R10: `in_take` equals the number of records represented by the slots loaded on the next edge: one per plain slot and two per fused slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cnt | input | CNTW | Number of valid records in the window |
| in_cls | input | 2*WIN | Class code per record (0 other, 1 compare, 2 test, 3 conditional jump) |
| in_opa | input | DW*WIN | First source operand per record |
| in_opb | input | DW*WIN | Second source operand per record |
| in_cond | input | CW*WIN | Condition code per record |
| in_tgt | input | TW*WIN | Jump target per record |
| in_take | output | CNTW | Records taken from the window this cycle |
| out_ready | input | 1 | Downstream can accept the slots |
| out_valid | output | 1 | Output slots hold at least one operation |
| out_vld | output | OUTS | Per-slot valid bits |
| out_fused | output | OUTS | Per-slot fused marker |
| out_cls | output | 2*OUTS | Class per slot (compare or test class for fused slots) |
| out_opa | output | DW*OUTS | First operand per slot |
| out_opb | output | DW*OUTS | Second operand per slot |
| out_cond | output | CW*OUTS | Condition per slot |
| out_tgt | output | TW*OUTS | Target per slot |

## Verification
The directed windows each isolate one decision:
- A window of plain records only shows the four-slot cap.
- A pair in the middle of a full window shows five records going into four slots.
- Two back-to-back pairs show that only the first is merged.
- A trailing compare shows the hold-back.
- A compare separated from its jump, and a jump with no compare before it, show that fusion needs strict adjacency.

A stalled handshake shows that the slots are held and nothing is taken. Long random windows with random ready then mix every class at every lane position. A behavioural model checks each slot field and the take count on every cycle.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_CMP  = 2'd1,
    CLS_TEST = 2'd2,
    CLS_JCC  = 2'd3
  } cls_e;
endpackage

// File: rtl/mf_pair_detect.sv
module mf_pair_detect
  import mf_pkg::*;
#(
  parameter int WIN  = 5,
  parameter int CNTW = 3
) (
  input  logic [1:0]      cls [WIN],
  input  logic [CNTW-1:0] cnt,
  output logic [WIN-1:0]  is_flag,
  output logic [WIN-1:0]  pair
);
  // one detector per lane: flag producer, and flag producer with a jump right behind it
  for (genvar i = 0; i < WIN; i++) begin : g_lane
    assign is_flag[i] = (cls[i] == CLS_CMP) || (cls[i] == CLS_TEST);
    if (i < WIN - 1) begin : g_pair
      assign pair[i] = is_flag[i] && (cls[i+1] == CLS_JCC) && (CNTW'(i + 1) < cnt);
    end else begin : g_last
      assign pair[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mf_slot_pick.sv
module mf_slot_pick #(
  parameter int WIN  = 5,
  parameter int OUTS = 4,
  parameter int DW   = 16,
  parameter int CW   = 4,
  parameter int TW   = 16,
  parameter int CNTW = 3
) (
  input  logic [CNTW-1:0] cnt,
  input  logic [1:0]      cls  [WIN],
  input  logic [DW-1:0]   opa  [WIN],
  input  logic [DW-1:0]   opb  [WIN],
  input  logic [CW-1:0]   cond [WIN],
  input  logic [TW-1:0]   tgt  [WIN],
  input  logic [WIN-1:0]  is_flag,
  input  logic [WIN-1:0]  pair,
  output logic [OUTS-1:0] nx_vld,
  output logic [OUTS-1:0] nx_fused,
  output logic [1:0]      nx_cls  [OUTS],
  output logic [DW-1:0]   nx_opa  [OUTS],
  output logic [DW-1:0]   nx_opb  [OUTS],
  output logic [CW-1:0]   nx_cond [OUTS],
  output logic [TW-1:0]   nx_tgt  [OUTS],
  output logic [CNTW-1:0] take
);
  localparam int PIW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int SIW = (OUTS > 1) ? $clog2(OUTS) : 1;
  localparam int OW  = $clog2(OUTS + 1);
  localparam logic [OW-1:0] NOUT = OW'(OUTS);

  logic [CNTW-1:0] pos, nxt;
  logic [OW-1:0]   n;
  logic            fz, halt;
  logic [PIW-1:0]  pi, pj;
  logic [SIW-1:0]  si;

  // walk the window in order; each step fills one slot or stops
  always_comb begin
    pos = '0; nxt = '0; n = '0; fz = 1'b0; halt = 1'b0;
    pi = '0; pj = '0; si = '0;
    nx_vld = '0; nx_fused = '0;
    for (int k = 0; k < OUTS; k++) begin
      nx_cls[k] = '0; nx_opa[k] = '0; nx_opb[k] = '0;
      nx_cond[k] = '0; nx_tgt[k] = '0;
    end
    for (int s = 0; s < WIN; s++) begin
      if (!halt && (pos < cnt) && (n < NOUT)) begin
        pi  = pos[PIW-1:0];
        nxt = pos + 1'b1;
        pj  = nxt[PIW-1:0];
        si  = n[SIW-1:0];
        nx_vld[si]  = 1'b1;
        nx_cls[si]  = cls[pi];
        nx_opa[si]  = opa[pi];
        nx_opb[si]  = opb[pi];
        nx_cond[si] = cond[pi];
        nx_tgt[si]  = tgt[pi];
        if (is_flag[pi] && (nxt == cnt)) begin
          // trailing compare waits for its partner
          halt       = 1'b1;
          nx_vld[si] = 1'b0;
        end else if (pair[pi] && !fz) begin
          nx_fused[si] = 1'b1;
          nx_cond[si]  = cond[pj];
          nx_tgt[si]   = tgt[pj];
          fz  = 1'b1;
          pos = pos + 2'd2;
          n   = n + 1'b1;
        end else begin
          pos = nxt;
          n   = n + 1'b1;
        end
      end
    end
    take = pos;
  end
endmodule

// File: rtl/mf_out_reg.sv
module mf_out_reg #(
  parameter int OUTS = 4,
  parameter int DW   = 16,
  parameter int CW   = 4,
  parameter int TW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [OUTS-1:0] nx_vld,
  input  logic [OUTS-1:0] nx_fused,
  input  logic [1:0]      nx_cls  [OUTS],
  input  logic [DW-1:0]   nx_opa  [OUTS],
  input  logic [DW-1:0]   nx_opb  [OUTS],
  input  logic [CW-1:0]   nx_cond [OUTS],
  input  logic [TW-1:0]   nx_tgt  [OUTS],
  output logic            q_valid,
  output logic [OUTS-1:0] q_vld,
  output logic [OUTS-1:0] q_fused,
  output logic [1:0]      q_cls  [OUTS],
  output logic [DW-1:0]   q_opa  [OUTS],
  output logic [DW-1:0]   q_opb  [OUTS],
  output logic [CW-1:0]   q_cond [OUTS],
  output logic [TW-1:0]   q_tgt  [OUTS]
);
  // control bits reset; payload does not need to
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_vld   <= '0;
    end else if (ld) begin
      q_valid <= |nx_vld;
      q_vld   <= nx_vld;
    end
    if (ld) begin
      q_fused <= nx_fused;
      q_cls   <= nx_cls;
      q_opa   <= nx_opa;
      q_opb   <= nx_opb;
      q_cond  <= nx_cond;
      q_tgt   <= nx_tgt;
    end
  end
endmodule

// File: rtl/mf_fuse_decode.sv
module mf_fuse_decode #(
  parameter int WIN  = 5,
  parameter int OUTS = 4,
  parameter int DW   = 16,
  parameter int CW   = 4,
  parameter int TW   = 16,
  parameter int CNTW = $clog2(WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNTW-1:0]      in_cnt,
  input  logic [2*WIN-1:0]     in_cls,
  input  logic [DW*WIN-1:0]    in_opa,
  input  logic [DW*WIN-1:0]    in_opb,
  input  logic [CW*WIN-1:0]    in_cond,
  input  logic [TW*WIN-1:0]    in_tgt,
  output logic [CNTW-1:0]      in_take,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [OUTS-1:0]      out_vld,
  output logic [OUTS-1:0]      out_fused,
  output logic [2*OUTS-1:0]    out_cls,
  output logic [DW*OUTS-1:0]   out_opa,
  output logic [DW*OUTS-1:0]   out_opb,
  output logic [CW*OUTS-1:0]   out_cond,
  output logic [TW*OUTS-1:0]   out_tgt
);
  logic [1:0]    w_cls  [WIN];
  logic [DW-1:0] w_opa  [WIN];
  logic [DW-1:0] w_opb  [WIN];
  logic [CW-1:0] w_cond [WIN];
  logic [TW-1:0] w_tgt  [WIN];

  for (genvar i = 0; i < WIN; i++) begin : g_unpack
    assign w_cls[i]  = in_cls[2*i +: 2];
    assign w_opa[i]  = in_opa[DW*i +: DW];
    assign w_opb[i]  = in_opb[DW*i +: DW];
    assign w_cond[i] = in_cond[CW*i +: CW];
    assign w_tgt[i]  = in_tgt[TW*i +: TW];
  end

  logic [WIN-1:0]  is_flag, pair;
  logic [OUTS-1:0] nx_vld, nx_fused;
  logic [1:0]      nx_cls  [OUTS];
  logic [DW-1:0]   nx_opa  [OUTS];
  logic [DW-1:0]   nx_opb  [OUTS];
  logic [CW-1:0]   nx_cond [OUTS];
  logic [TW-1:0]   nx_tgt  [OUTS];
  logic [CNTW-1:0] take;
  logic            ld;

  logic [1:0]      q_cls  [OUTS];
  logic [DW-1:0]   q_opa  [OUTS];
  logic [DW-1:0]   q_opb  [OUTS];
  logic [CW-1:0]   q_cond [OUTS];
  logic [TW-1:0]   q_tgt  [OUTS];

  mf_pair_detect #(.WIN(WIN), .CNTW(CNTW)) u_det (
    .cls(w_cls), .cnt(in_cnt), .is_flag(is_flag), .pair(pair)
  );

  mf_slot_pick #(.WIN(WIN), .OUTS(OUTS), .DW(DW), .CW(CW), .TW(TW), .CNTW(CNTW)) u_pick (
    .cnt(in_cnt), .cls(w_cls), .opa(w_opa), .opb(w_opb), .cond(w_cond), .tgt(w_tgt),
    .is_flag(is_flag), .pair(pair),
    .nx_vld(nx_vld), .nx_fused(nx_fused), .nx_cls(nx_cls), .nx_opa(nx_opa),
    .nx_opb(nx_opb), .nx_cond(nx_cond), .nx_tgt(nx_tgt), .take(take)
  );

  assign ld      = !out_valid || out_ready;
  assign in_take = ld ? take : '0;

  mf_out_reg #(.OUTS(OUTS), .DW(DW), .CW(CW), .TW(TW)) u_oreg (
    .clk(clk), .rst(rst), .ld(ld),
    .nx_vld(nx_vld), .nx_fused(nx_fused), .nx_cls(nx_cls), .nx_opa(nx_opa),
    .nx_opb(nx_opb), .nx_cond(nx_cond), .nx_tgt(nx_tgt),
    .q_valid(out_valid), .q_vld(out_vld), .q_fused(out_fused), .q_cls(q_cls),
    .q_opa(q_opa), .q_opb(q_opb), .q_cond(q_cond), .q_tgt(q_tgt)
  );

  for (genvar j = 0; j < OUTS; j++) begin : g_pack
    assign out_cls[2*j +: 2]    = q_cls[j];
    assign out_opa[DW*j +: DW]  = q_opa[j];
    assign out_opb[DW*j +: DW]  = q_opb[j];
    assign out_cond[CW*j +: CW] = q_cond[j];
    assign out_tgt[TW*j +: TW]  = q_tgt[j];
  end
endmodule

// File: rtl/mf_fuse_decode_chk.sv
module mf_fuse_decode_chk #(
  parameter int OUTS = 4,
  parameter int DW   = 16,
  parameter int CNTW = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                out_ready,
  input logic                out_valid,
  input logic [OUTS-1:0]     out_vld,
  input logic [OUTS-1:0]     out_fused,
  input logic [2*OUTS-1:0]   out_cls,
  input logic [DW*OUTS-1:0]  out_opa,
  input logic [CNTW-1:0]     in_take
);
  logic [OUTS-1:0] vld_inc;
  assign vld_inc = out_vld + 1'b1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_vld == '0)));

  p_slot_prefix_r2: assert property (@(posedge clk) disable iff (rst)
    ((vld_inc & out_vld) == '0));

  for (genvar j = 0; j < OUTS; j++) begin : g_slot
    p_fused_cls_r3: assert property (@(posedge clk) disable iff (rst)
      (out_vld[j] && out_fused[j]) |-> (out_cls[2*j +: 2] inside {2'd1, 2'd2}));
  end

  p_one_fuse_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_vld & out_fused) <= 1));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_vld) && $stable(out_fused) && $stable(out_opa)));

  p_take_match_r10: assert property (@(posedge clk) disable iff (rst)
    (in_take != '0) |=>
      (($countones(out_vld) + $countones(out_vld & out_fused)) == int'($past(in_take))));
endmodule

bind mf_fuse_decode mf_fuse_decode_chk #(.OUTS(OUTS), .DW(DW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .out_ready(out_ready), .out_valid(out_valid),
  .out_vld(out_vld), .out_fused(out_fused), .out_cls(out_cls),
  .out_opa(out_opa), .in_take(in_take)
);

// File: tb/mf_fuse_decode_tb.sv
module mf_fuse_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 5, OUTS = 4, DW = 16, CW = 4, TW = 16, CNTW = 3;

  logic clk = 1'b0, rst = 1'b1, out_ready = 1'b1;
  logic [CNTW-1:0] in_cnt = '0;
  logic [2*WIN-1:0] in_cls = '0;
  logic [DW*WIN-1:0] in_opa = '0, in_opb = '0;
  logic [CW*WIN-1:0] in_cond = '0;
  logic [TW*WIN-1:0] in_tgt = '0;
  logic [CNTW-1:0] in_take;
  logic out_valid;
  logic [OUTS-1:0] out_vld, out_fused;
  logic [2*OUTS-1:0] out_cls;
  logic [DW*OUTS-1:0] out_opa, out_opb;
  logic [CW*OUTS-1:0] out_cond;
  logic [TW*OUTS-1:0] out_tgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mf_fuse_decode #(.WIN(WIN), .OUTS(OUTS), .DW(DW), .CW(CW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_cls(in_cls), .in_opa(in_opa),
    .in_opb(in_opb), .in_cond(in_cond), .in_tgt(in_tgt), .in_take(in_take),
    .out_ready(out_ready), .out_valid(out_valid), .out_vld(out_vld),
    .out_fused(out_fused), .out_cls(out_cls), .out_opa(out_opa), .out_opb(out_opb),
    .out_cond(out_cond), .out_tgt(out_tgt)
  );

  int n_cmp = 0, n_bad = 0;

  // bench-side window
  int b_cnt;
  logic [1:0] b_cls [WIN];
  logic [DW-1:0] b_opa [WIN], b_opb [WIN];
  logic [CW-1:0] b_cond [WIN];
  logic [TW-1:0] b_tgt [WIN];

  // model of the registered slots
  bit e_valid;
  bit e_vld [OUTS], e_fused [OUTS];
  logic [1:0] e_cls [OUTS];
  logic [DW-1:0] e_opa [OUTS], e_opb [OUTS];
  logic [CW-1:0] e_cond [OUTS];
  logic [TW-1:0] e_tgt [OUTS];

  // candidate slots for the current window
  bit n_vld [OUTS], n_fused [OUTS];
  logic [1:0] n_cls [OUTS];
  logic [DW-1:0] n_opa [OUTS], n_opb [OUTS];
  logic [CW-1:0] n_cond [OUTS];
  logic [TW-1:0] n_tgt [OUTS];
  int n_take, n_ops;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_cmp(logic [1:0] c);
    return (c == 2'd1) || (c == 2'd2);
  endfunction

  task automatic put(int k, int p, bit fz);
    n_vld[k] = 1; n_fused[k] = fz; n_cls[k] = b_cls[p];
    n_opa[k] = b_opa[p]; n_opb[k] = b_opb[p];
    n_cond[k] = fz ? b_cond[p+1] : b_cond[p];
    n_tgt[k]  = fz ? b_tgt[p+1]  : b_tgt[p];
  endtask

  // expected slots from the requirements: in order, first pair merged, trailing compare held
  task automatic ref_eval();
    int p; bit used; bit stop;
    p = 0; used = 0; stop = 0; n_ops = 0;
    for (int k = 0; k < OUTS; k++) begin n_vld[k] = 0; n_fused[k] = 0; end
    while (!stop && p < b_cnt && n_ops < OUTS) begin
      if (is_cmp(b_cls[p]) && p == b_cnt - 1) stop = 1;
      else if (is_cmp(b_cls[p]) && !used && b_cls[p+1] == 2'd3) begin
        put(n_ops, p, 1); used = 1; n_ops++; p += 2;
      end else begin
        put(n_ops, p, 0); n_ops++; p++;
      end
    end
    n_take = p;
  endtask

  task automatic drive();
    in_cnt = CNTW'(b_cnt);
    for (int i = 0; i < WIN; i++) begin
      in_cls[2*i +: 2] = b_cls[i];
      in_opa[DW*i +: DW] = b_opa[i];
      in_opb[DW*i +: DW] = b_opb[i];
      in_cond[CW*i +: CW] = b_cond[i];
      in_tgt[TW*i +: TW] = b_tgt[i];
    end
  endtask

  task automatic setw(int cnt, logic [1:0] c0, logic [1:0] c1, logic [1:0] c2,
                      logic [1:0] c3, logic [1:0] c4);
    b_cnt = cnt;
    b_cls[0] = c0; b_cls[1] = c1; b_cls[2] = c2; b_cls[3] = c3; b_cls[4] = c4;
    for (int i = 0; i < WIN; i++) begin
      b_opa[i] = DW'($urandom); b_opb[i] = DW'($urandom);
      b_cond[i] = CW'($urandom); b_tgt[i] = TW'($urandom);
    end
  endtask

  task automatic compare_out(string tag);
    check(tag, "out_valid", 64'(out_valid), 64'(e_valid));
    for (int k = 0; k < OUTS; k++) begin
      check(tag, "out_vld", 64'(out_vld[k]), 64'(e_vld[k]));
      if (e_vld[k]) begin
        check(tag, "out_fused", 64'(out_fused[k]), 64'(e_fused[k]));
        check(tag, "out_cls", 64'(out_cls[2*k +: 2]), 64'(e_cls[k]));
        check(tag, "out_opa", 64'(out_opa[DW*k +: DW]), 64'(e_opa[k]));
        check(tag, "out_opb", 64'(out_opb[DW*k +: DW]), 64'(e_opb[k]));
        check(tag, "out_cond", 64'(out_cond[CW*k +: CW]), 64'(e_cond[k]));
        check(tag, "out_tgt", 64'(out_tgt[TW*k +: TW]), 64'(e_tgt[k]));
      end
    end
  endtask

  // one clock: drive window, check take before the edge, check slots after it
  task automatic cyc(string tag);
    bit ld;
    drive();
    ld = !e_valid || out_ready;
    ref_eval();
    #1;
    check(tag, "in_take", 64'(in_take), ld ? 64'(n_take) : 64'd0);
    @(posedge clk);
    #1;
    if (ld) begin
      e_valid = (n_ops > 0);
      for (int k = 0; k < OUTS; k++) begin
        e_vld[k] = n_vld[k]; e_fused[k] = n_fused[k]; e_cls[k] = n_cls[k];
        e_opa[k] = n_opa[k]; e_opb[k] = n_opb[k];
        e_cond[k] = n_cond[k]; e_tgt[k] = n_tgt[k];
      end
    end
    compare_out(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    setw(0, 0, 0, 0, 0, 0);
    drive();
    e_valid = 0;
    for (int k = 0; k < OUTS; k++) begin e_vld[k] = 0; e_fused[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1", "out_valid", 64'(out_valid), 64'd0);
    check("R1", "out_vld", 64'(out_vld), 64'd0);
    rst = 1'b0;

    out_ready = 1'b1;
    setw(4, 0, 0, 0, 0, 0); cyc("R2");               // four plain records
    setw(5, 0, 3, 0, 0, 0); cyc("R2");               // five records, four slots
    setw(5, 0, 1, 3, 0, 0); cyc("R3");               // pair in lanes 1-2
    setw(5, 0, 0, 0, 2, 3); cyc("R4");               // pair at end, five taken
    setw(5, 1, 3, 2, 3, 0); cyc("R5");               // two pairs, first merged
    setw(5, 2, 3, 1, 0, 1); cyc("R5");               // held compare after a fusion
    setw(3, 0, 0, 2, 0, 0); cyc("R6");               // trailing test held
    setw(1, 1, 0, 0, 0, 0); cyc("R6");               // lone compare held
    setw(4, 1, 0, 3, 0, 0); cyc("R7");               // compare not adjacent to jump
    setw(3, 3, 1, 3, 0, 0); cyc("R7");               // jump first, then pair
    setw(0, 0, 0, 0, 0, 0); cyc("R9");               // empty window

    setw(4, 0, 1, 3, 0, 0); cyc("R8");
    out_ready = 1'b0;
    setw(5, 0, 0, 0, 0, 0); cyc("R8");
    setw(5, 2, 3, 0, 0, 0); cyc("R8");
    out_ready = 1'b1;
    cyc("R8");

    for (int t = 0; t < 400; t++) begin
      out_ready = ($urandom_range(0, 3) != 0);
      setw($urandom_range(0, WIN), 2'($urandom), 2'($urandom), 2'($urandom),
           2'($urandom), 2'($urandom));
      cyc("R10");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule